// File: doc/BRIEF.md
# Programmable External Chip-Select Unit

This block sits between an on-chip bus master and an external memory interface. Seven regions can be programmed, each with its own base, mask and control settings. On every bus cycle the unit compares the upper half of the address against each enabled region. It drives the chip-select line of the winning region low for the whole cycle. It also produces a read output enable and active-low byte-lane strobes that suit the port width of the selected device. The cycle ends after a programmed number of wait states or when an external acknowledge arrives.

After reset only region 0 is enabled, and it covers the whole address space, so boot code can be fetched from an external ROM before software sets anything up. The port width of that boot region comes from two configuration pins. They are sampled when the external reset-out signal rises while the configuration strap is high. Software then programs the regions through a write-only register port. It picks a region, picks one of its three registers, and supplies a data word.

Top module: `xcs_unit`

## Requirements
- R1: The unit drives `cs_n[6:0]` active low, and at most one of these lines is low at any time. When an address falls inside several enabled regions, the region with the lowest index is selected.
- R2: A region matches when it is enabled and `((addr[31:16] ^ base) & ~mask) == 0`. A mask bit of 1 excludes that address bit from the compare. Address bits 15:0 never take part in the match.
- R3: After reset all outputs are idle: `cs_n` all ones, `oe_n` = 1, `bs_n` = 4'hF, `int_ta` = 0 and `wp_err` = 0. Region 0 is enabled with a full mask, 15 wait states, internal termination and strobes on reads and writes. Regions 1 to 6 are disabled.
- R4: Region 0's port size is loaded from `boot_d` on the clock where `rst_out_n` is first seen high after being low, but only if `boot_cfg` is 1. If it is not loaded, the port size stays 32-bit (code 00).
- R5: `oe_n` changes only on the falling clock edge. It is low only during an accepted read cycle and follows that cycle's chip select by half a clock.
- R6: Transfer size codes are 00 longword, 01 byte and 10 word. Port size codes are 00 for 32-bit, 01 for 8-bit, and 10 or 11 for 16-bit. `bs_n[3]` is the most significant byte lane. The lanes are as follows:
  - 32-bit port: a longword uses all four lanes; a word uses lanes 3:2 when A1=0 and lanes 1:0 when A1=1; a byte uses lane 3−A[1:0].
  - 16-bit port: a longword or word uses lanes 3:2; a byte uses lane 3 when A0=0 and lane 2 when A0=1.
  - 8-bit port: every transfer uses lane 3 only.
- R7: When a region's byte-enable mode bit is 0, the strobes stay high on reads and assert only on writes. When the bit is 1, they assert on both reads and writes.
- R8: With internal termination, the chip select stays low for the wait count plus one clocks. `int_ta` is high for exactly the last of those clocks.
- R9: With external termination, the cycle ends on the clock edge where `ext_ta_n` is sampled low, and `int_ta` stays low.
- R10: A write to a region whose protect bit is set asserts no chip select, no strobe and no output enable. It raises `wp_err` for one clock. Reads from that region proceed normally.
- R11: The register port is `reg_kind` 0 for base, 1 for mask and 2 for control. Base and mask take `reg_wdata[31:16]`. The control word is laid out as follows:
  - [1:0] port size
  - [2] byte-enable mode
  - [3] internal termination
  - [7:4] wait count
  - [8] write protect
  - [9] enable
- R12: A cycle whose address matches no enabled region asserts no chip select, no output enable and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_out_n | input | 1 | External reset-out level, rising edge captures the boot port size |
| boot_cfg | input | 1 | Configuration strap enabling boot port-size capture |
| boot_d | input | 2 | Boot port-size pins |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Region index for the write |
| reg_kind | input | 2 | Register within the region (base, mask, control) |
| reg_wdata | input | 32 | Register write data |
| cyc_start | input | 1 | Starts a bus cycle (ignored while a cycle is in progress) |
| cyc_addr | input | 32 | Cycle address |
| cyc_rd | input | 1 | 1 for read, 0 for write |
| cyc_siz | input | 2 | Transfer size code |
| ext_ta_n | input | 1 | External transfer acknowledge, active low |
| cs_n | output | 7 | Chip selects, active low |
| oe_n | output | 1 | Read output enable, active low, falling-edge timed |
| bs_n | output | 4 | Byte-lane strobes, active low |
| int_ta | output | 1 | Internal termination pulse |
| wp_err | output | 1 | Write-protect violation pulse |

## Verification
Several properties are checked on every clock edge:
- at most one chip select is low;
- the output enable never appears without a chip select;
- the strobes stay idle whenever no chip select is low;
- a write-protect error never coincides with a chip select;
- the internal acknowledge never lasts two clocks;
- the wait counter steps down by one per clock.

Other behaviour needs the bench's directed cycles to show it, because it depends on the programmed values:
- which region wins an overlap;
- the exact strobe pattern for each port width, size and offset;
- the cycle length for a given wait count or acknowledge delay;
- the boot port-size capture with the strap high or low.

// File: rtl/xcs_pkg.sv
package xcs_pkg;

   localparam int WS_W = 4;

   typedef enum logic [1:0] {
      PS_32  = 2'b00,
      PS_8   = 2'b01,
      PS_16A = 2'b10,
      PS_16B = 2'b11
   } psize_e;

   typedef enum logic [1:0] {
      SZ_LONG = 2'b00,
      SZ_BYTE = 2'b01,
      SZ_WORD = 2'b10,
      SZ_RSVD = 2'b11
   } tsize_e;

   typedef enum logic [1:0] {
      RK_BASE = 2'b00,
      RK_MASK = 2'b01,
      RK_CTRL = 2'b10,
      RK_NONE = 2'b11
   } rkind_e;

   // control word, LSB first: psize, bem, int_term, waits, wprot, valid
   typedef struct packed {
      logic            valid;
      logic            wprot;
      logic [WS_W-1:0] waits;
      logic            int_term;
      logic            bem;
      logic [1:0]      psize;
   } rctl_t;

   localparam int CTL_W = $bits(rctl_t);

endpackage

// File: rtl/xcs_region.sv
module xcs_region
   import xcs_pkg::*;
#(
   parameter int AW      = 32,
   parameter int HIW     = 16,
   parameter bit IS_BOOT = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic [1:0]     wr_kind,
   input  logic [AW-1:0]  wr_data,
   input  logic           boot_ld,
   input  logic [1:0]     boot_ps,
   input  logic [HIW-1:0] addr_hi,
   output logic           hit,
   output rctl_t          ctl
);

   localparam rctl_t BOOT_CTL = '{valid: 1'b1, wprot: 1'b0, waits: '1,
                                  int_term: 1'b1, bem: 1'b1, psize: 2'b00};
   localparam rctl_t RST_CTL  = IS_BOOT ? BOOT_CTL : '0;
   localparam logic [HIW-1:0] RST_MASK = IS_BOOT ? '1 : '0;

   logic [HIW-1:0] base_q;
   logic [HIW-1:0] mask_q;
   rctl_t          ctl_q;
   logic           unused_wd;

   generate
      if (CTL_W > AW - HIW) begin : g_bad_layout
         $error("xcs_region: control word overlaps the base/mask field");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         mask_q <= RST_MASK;
         ctl_q  <= RST_CTL;
      end else begin
         if (wr_en) begin
            case (rkind_e'(wr_kind))
               RK_BASE: base_q <= wr_data[AW-1 -: HIW];
               RK_MASK: mask_q <= wr_data[AW-1 -: HIW];
               RK_CTRL: ctl_q  <= rctl_t'(wr_data[CTL_W-1:0]);
               default: ;
            endcase
         end
         if (IS_BOOT && boot_ld) ctl_q.psize <= boot_ps;
      end
   end

   assign hit       = ctl_q.valid && (((addr_hi ^ base_q) & ~mask_q) == '0);
   assign ctl       = ctl_q;
   assign unused_wd = ^wr_data[AW-HIW-1:CTL_W];

endmodule

// File: rtl/xcs_lanes.sv
module xcs_lanes
   import xcs_pkg::*;
(
   input  logic [1:0] siz,
   input  logic [1:0] a_lo,
   input  logic [1:0] psize,
   output logic [3:0] lanes
);

   always_comb begin
      lanes = 4'b0000;
      case (psize_e'(psize))
         PS_8: lanes = 4'b1000;
         PS_16A, PS_16B: begin
            if (tsize_e'(siz) == SZ_BYTE) lanes = a_lo[0] ? 4'b0100 : 4'b1000;
            else                          lanes = 4'b1100;
         end
         default: begin
            case (tsize_e'(siz))
               SZ_BYTE: lanes = 4'b1000 >> a_lo;
               SZ_WORD: lanes = a_lo[1] ? 4'b0011 : 4'b1100;
               default: lanes = 4'b1111;
            endcase
         end
      endcase
   end

endmodule

// File: rtl/xcs_waitctr.sv
module xcs_waitctr #(
   parameter int WS_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [WS_W-1:0] load_val,
   input  logic            run,
   output logic            zero
);

   logic [WS_W-1:0] cnt_q;

   generate
      if (WS_W < 1 || WS_W > 16) begin : g_bad_ws
         $error("xcs_waitctr: WS_W out of range");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (load)                   cnt_q <= load_val;
      else if (run && cnt_q != '0)     cnt_q <= cnt_q - WS_W'(1);
   end

   assign zero = (cnt_q == '0);

   // R8
   dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - WS_W'(1)));

endmodule

// File: rtl/xcs_unit.sv
module xcs_unit
   import xcs_pkg::*;
#(
   parameter int NREG = 7,
   parameter int AW   = 32,
   parameter int HIW  = 16,
   parameter int SELW = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rst_out_n,
   input  logic            boot_cfg,
   input  logic [1:0]      boot_d,
   input  logic            reg_we,
   input  logic [SELW-1:0] reg_sel,
   input  logic [1:0]      reg_kind,
   input  logic [AW-1:0]   reg_wdata,
   input  logic            cyc_start,
   input  logic [AW-1:0]   cyc_addr,
   input  logic            cyc_rd,
   input  logic [1:0]      cyc_siz,
   input  logic            ext_ta_n,
   output logic [NREG-1:0] cs_n,
   output logic            oe_n,
   output logic [3:0]      bs_n,
   output logic            int_ta,
   output logic            wp_err
);

   localparam int LANES = 4;

   generate
      if (NREG < 1 || NREG > 8) begin : g_bad_nreg
         $error("xcs_unit: NREG must be 1..8");
      end
      if (HIW < 1 || HIW >= AW) begin : g_bad_hiw
         $error("xcs_unit: HIW must be below AW");
      end
   endgenerate

   // boot port-size capture on rising reset-out
   logic rso_q;
   logic boot_ld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rso_q <= 1'b1;
      else        rso_q <= rst_out_n;
   end
   assign boot_ld = !rso_q && rst_out_n && boot_cfg;

   // region array
   logic [NREG-1:0] hit;
   rctl_t           ctl_arr [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      xcs_region #(.AW(AW), .HIW(HIW), .IS_BOOT(g == 0)) i_region (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (reg_we && (reg_sel == SELW'(g))),
         .wr_kind (reg_kind),
         .wr_data (reg_wdata),
         .boot_ld (boot_ld),
         .boot_ps (boot_d),
         .addr_hi (cyc_addr[AW-1 -: HIW]),
         .hit     (hit[g]),
         .ctl     (ctl_arr[g])
      );
   end

   // lowest index wins
   logic            any_hit;
   logic [NREG-1:0] sel_oh;
   rctl_t           sel_ctl;

   always_comb begin
      any_hit = 1'b0;
      sel_oh  = '0;
      sel_ctl = '0;
      for (int i = NREG - 1; i >= 0; i--) begin
         if (hit[i]) begin
            any_hit   = 1'b1;
            sel_oh    = '0;
            sel_oh[i] = 1'b1;
            sel_ctl   = ctl_arr[i];
         end
      end
   end

   // cycle state
   logic            active_q;
   logic [NREG-1:0] csv_q;
   logic            rd_q;
   logic [1:0]      siz_q;
   logic [1:0]      alo_q;
   logic [1:0]      ps_q;
   logic            bem_q;
   logic            iterm_q;
   logic            err_q;
   logic            start_ok;
   logic            blocked;
   logic            wait_zero;
   logic            end_now;

   assign start_ok = cyc_start && !active_q;
   assign blocked  = any_hit && sel_ctl.wprot && !cyc_rd;
   assign end_now  = iterm_q ? wait_zero : !ext_ta_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         csv_q    <= '0;
         rd_q     <= 1'b0;
         siz_q    <= '0;
         alo_q    <= '0;
         ps_q     <= '0;
         bem_q    <= 1'b0;
         iterm_q  <= 1'b0;
         err_q    <= 1'b0;
      end else if (start_ok) begin
         active_q <= any_hit && !blocked;
         csv_q    <= blocked ? '0 : sel_oh;
         rd_q     <= cyc_rd;
         siz_q    <= cyc_siz;
         alo_q    <= cyc_addr[1:0];
         ps_q     <= sel_ctl.psize;
         bem_q    <= sel_ctl.bem;
         iterm_q  <= sel_ctl.int_term;
         err_q    <= blocked;
      end else begin
         err_q <= 1'b0;
         if (active_q && end_now) begin
            active_q <= 1'b0;
            csv_q    <= '0;
         end
      end
   end

   xcs_waitctr #(.WS_W(WS_W)) i_wait (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start_ok),
      .load_val (sel_ctl.waits),
      .run      (active_q),
      .zero     (wait_zero)
   );

   // output enable on the falling edge
   logic oe_q;
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) oe_q <= 1'b1;
      else        oe_q <= !(active_q && rd_q);
   end

   logic [LANES-1:0] lanes;
   xcs_lanes i_lanes (
      .siz   (siz_q),
      .a_lo  (alo_q),
      .psize (ps_q),
      .lanes (lanes)
   );

   assign cs_n   = ~csv_q;
   assign oe_n   = oe_q;
   assign bs_n   = (active_q && (!rd_q || bem_q)) ? ~lanes : '1;
   assign int_ta = active_q && iterm_q && wait_zero;
   assign wp_err = err_q;

   logic unused_top;
   assign unused_top = ^{cyc_addr[AW-HIW-1:2], sel_ctl.valid};

   // R1
   cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));

   // R5
   oe_with_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |-> (cs_n != '1));

   // R12
   bs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n == '1) |-> (bs_n == 4'hF));

   // R10
   wp_no_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wp_err |-> (cs_n == '1));

   // R8
   ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_ta |=> !int_ta);

endmodule

// File: tb/test_xcs_unit.sv
module test_xcs_unit;

   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rst_out_n = 1'b0;
   logic       boot_cfg = 1'b1;
   logic [1:0] boot_d = 2'b01;
   logic       reg_we = 1'b0;
   logic [2:0] reg_sel = '0;
   logic [1:0] reg_kind = '0;
   logic [31:0] reg_wdata = '0;
   logic       cyc_start = 1'b0;
   logic [31:0] cyc_addr = '0;
   logic       cyc_rd = 1'b0;
   logic [1:0] cyc_siz = '0;
   logic       ext_ta_n = 1'b1;
   logic [6:0] cs_n;
   logic       oe_n;
   logic [3:0] bs_n;
   logic       int_ta;
   logic       wp_err;

   always #(CLK_P/2) clk = ~clk;

   xcs_unit i_xcs_unit (
      .clk(clk), .rst_n(rst_n), .rst_out_n(rst_out_n), .boot_cfg(boot_cfg),
      .boot_d(boot_d), .reg_we(reg_we), .reg_sel(reg_sel), .reg_kind(reg_kind),
      .reg_wdata(reg_wdata), .cyc_start(cyc_start), .cyc_addr(cyc_addr),
      .cyc_rd(cyc_rd), .cyc_siz(cyc_siz), .ext_ta_n(ext_ta_n), .cs_n(cs_n),
      .oe_n(oe_n), .bs_n(bs_n), .int_ta(int_ta), .wp_err(wp_err)
   );

   typedef struct {
      logic [6:0] cs;
      logic [3:0] bs;
      bit         oe;
      int         len;
      int         acks;
      bit         err;
   } item_t;

   item_t exp_q[$];
   string req_q[$];
   int    checks = 0;
   int    errors = 0;
   bit    finished = 1'b0;

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic report();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   task automatic expect_item(logic [6:0] cs, logic [3:0] bs, bit oe, int len,
                              int acks, bit err, string req);
      item_t it;
      it.cs = cs; it.bs = bs; it.oe = oe; it.len = len; it.acks = acks; it.err = err;
      exp_q.push_back(it);
      req_q.push_back(req);
   endtask

   task automatic compare(item_t ob);
      item_t ex;
      string rq;
      if (exp_q.size() == 0) begin
         chk(1'b0, "R1", "unexpected cycle cs_n", int'(ob.cs), 7'h7F);
         return;
      end
      ex = exp_q.pop_front();
      rq = req_q.pop_front();
      chk(ob.cs == ex.cs, rq, "cs_n", int'(ob.cs), int'(ex.cs));
      chk(ob.bs == ex.bs, rq, "bs_n", int'(ob.bs), int'(ex.bs));
      chk(ob.oe == ex.oe, rq, "oe asserted", int'(ob.oe), int'(ex.oe));
      chk(ob.len == ex.len, rq, "cycle length", ob.len, ex.len);
      chk(ob.acks == ex.acks, rq, "int_ta count", ob.acks, ex.acks);
      chk(ob.err == ex.err, rq, "wp_err", int'(ob.err), int'(ex.err));
   endtask

   // monitor
   bit    in_win = 1'b0;
   item_t w;
   initial begin
      forever begin
         @(posedge clk);
         #7;
         if (!rst_n) begin
            in_win = 1'b0;
         end else begin
            if (wp_err) begin
               item_t e;
               e.cs = cs_n; e.bs = bs_n; e.oe = !oe_n; e.len = 0; e.acks = 0; e.err = 1'b1;
               compare(e);
            end
            if (!in_win && cs_n != 7'h7F) begin
               in_win = 1'b1;
               w.cs = cs_n; w.bs = bs_n; w.oe = 1'b0; w.len = 0; w.acks = 0; w.err = 1'b0;
            end
            if (in_win) begin
               if (cs_n == 7'h7F) begin
                  in_win = 1'b0;
                  compare(w);
               end else begin
                  w.len++;
                  if (!oe_n) w.oe = 1'b1;
                  if (int_ta) w.acks++;
               end
            end
         end
      end
   end

   task automatic wr_reg(logic [2:0] sel, logic [1:0] kind, logic [31:0] data);
      @(posedge clk); #1;
      reg_we = 1'b1; reg_sel = sel; reg_kind = kind; reg_wdata = data;
      @(posedge clk); #1;
      reg_we = 1'b0;
   endtask

   task automatic bus(logic [31:0] addr, logic rd, logic [1:0] siz, int ext_d);
      @(posedge clk); #1;
      cyc_start = 1'b1; cyc_addr = addr; cyc_rd = rd; cyc_siz = siz;
      @(posedge clk); #1;
      cyc_start = 1'b0;
      if (ext_d >= 0) begin
         repeat (ext_d) @(posedge clk);
         #1 ext_ta_n = 1'b0;
         @(posedge clk); #1;
         ext_ta_n = 1'b1;
      end
      repeat (20) @(posedge clk);
   endtask

   task automatic check_idle(string req);
      chk(cs_n == 7'h7F, req, "cs_n idle", int'(cs_n), 7'h7F);
      chk(oe_n == 1'b1, req, "oe_n idle", int'(oe_n), 1);
      chk(bs_n == 4'hF, req, "bs_n idle", int'(bs_n), 4'hF);
   endtask

   task automatic do_reset(bit cfg);
      @(posedge clk); #1;
      rst_n = 1'b0; rst_out_n = 1'b0; boot_cfg = cfg; boot_d = 2'b01;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #2;
      check_idle("R3");
      chk(int_ta == 1'b0 && wp_err == 1'b0, "R3", "int_ta/wp_err", int'({int_ta, wp_err}), 0);
      repeat (2) @(posedge clk);
      #1 rst_out_n = 1'b1;
      repeat (2) @(posedge clk);
   endtask

   // watchdog
   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         chk(1'b0, "R1", "watchdog expired", 0, 1);
         report();
      end
   end

   initial begin
      do_reset(1'b1);

      // R4 R3 R8: boot region, 8-bit port from pins, 15 waits
      expect_item(7'b1111110, 4'b0111, 1'b1, 16, 1, 1'b0, "R4");
      bus(32'h1234_0000, 1'b1, 2'b00, -1);

      // R11: program regions
      wr_reg(3'd0, 2'd0, 32'h0000_0000);
      wr_reg(3'd0, 2'd1, 32'h000F_0000);
      wr_reg(3'd0, 2'd2, 32'h0000_020C);
      wr_reg(3'd1, 2'd0, 32'h8000_0000);
      wr_reg(3'd1, 2'd1, 32'h0000_0000);
      wr_reg(3'd1, 2'd2, 32'h0000_022A);
      wr_reg(3'd2, 2'd0, 32'h8000_0000);
      wr_reg(3'd2, 2'd1, 32'h00FF_0000);
      wr_reg(3'd2, 2'd2, 32'h0000_0204);
      wr_reg(3'd3, 2'd0, 32'h4000_0000);
      wr_reg(3'd3, 2'd1, 32'h0000_0000);
      wr_reg(3'd3, 2'd2, 32'h0000_031D);

      // R6 R2: 32-bit port word at A1=1
      expect_item(7'b1111110, 4'b1100, 1'b1, 1, 1, 1'b0, "R6");
      bus(32'h0001_2346, 1'b1, 2'b10, -1);
      // R6: byte write at offset 3
      expect_item(7'b1111110, 4'b1110, 1'b0, 1, 1, 1'b0, "R6");
      bus(32'h0000_0003, 1'b0, 2'b01, -1);
      // R1 R7 R8: overlap, region 1 wins, read strobes off, 2 waits
      expect_item(7'b1111101, 4'b1111, 1'b1, 3, 1, 1'b0, "R7");
      bus(32'h8000_1235, 1'b1, 2'b01, -1);
      // R2 R7: low address bits ignored, write strobes on 16-bit port
      expect_item(7'b1111101, 4'b0011, 1'b0, 3, 1, 1'b0, "R2");
      bus(32'h8000_FFFC, 1'b0, 2'b00, -1);
      // R9: region 2 external termination after 3 extra clocks
      expect_item(7'b1111011, 4'b0000, 1'b1, 4, 0, 1'b0, "R9");
      bus(32'h8012_0000, 1'b1, 2'b00, 3);

      // R12: unmatched address
      @(posedge clk); #1;
      cyc_start = 1'b1; cyc_addr = 32'h0010_0000; cyc_rd = 1'b1; cyc_siz = 2'b00;
      @(posedge clk); #1;
      cyc_start = 1'b0;
      #5;
      check_idle("R12");
      repeat (5) @(posedge clk);

      // R10: protected write blocked, then read allowed
      expect_item(7'b1111111, 4'b1111, 1'b0, 0, 0, 1'b1, "R10");
      bus(32'h4000_0000, 1'b0, 2'b01, -1);
      expect_item(7'b1110111, 4'b0111, 1'b1, 2, 1, 1'b0, "R10");
      bus(32'h4000_0001, 1'b1, 2'b01, -1);

      // R4 R3: reset with strap low, port stays 32-bit; region 1 disabled again
      do_reset(1'b0);
      expect_item(7'b1111110, 4'b0000, 1'b1, 16, 1, 1'b0, "R4");
      bus(32'hFFFF_0000, 1'b1, 2'b00, -1);
      expect_item(7'b1111110, 4'b0011, 1'b1, 16, 1, 1'b0, "R3");
      bus(32'h8000_0000, 1'b1, 2'b10, -1);

      repeat (5) @(posedge clk);
      chk(exp_q.size() == 0, "R1", "pending expected items", exp_q.size(), 0);
      finished = 1'b1;
      report();
   end

endmodule